// File: doc/BRIEF.md
# Serial flash command controller

This block is the command front end of a serial-peripheral-interface flash device. It watches chip select, serial clock and serial data in, all sampled by the chip's own system clock. Opcode bits are collected on rising serial-clock edges while chip select is low. When chip select returns high, the controller decides whether to run the command. A command runs only when exactly eight bits were shifted in, so one extra or one missing clock cancels it. Both idle-low (mode 0) and idle-high (mode 3) serial-clock polarity are accepted.

The controller keeps a small status byte. It holds the write-in-progress flag, the write-enable latch and three block-protect bits that come from nonvolatile configuration. The byte is returned on the serial output during a status read. Whole-array erase is modelled as a one-cycle clear strobe to the array followed by a timed busy window. The controller also handles entry into and exit from a deep power-down state, each after a programmable delay.

Top module: `spi_flash_cmd_ctrl`

## Requirements
- R1: A command takes effect only if chip select rises after exactly 8 serial-clock rising edges. With 7 or 9 edges the command is discarded and the status byte is unchanged.
- R2: Opcode 0x06 (write enable) sets the write-enable latch, status bit 1, when the controller is idle and out of power-down.
- R3: Opcode 0xC7 (whole-array erase) is ignored unless the write-enable latch is 1 and all three protect inputs, reported as status bits 4..2, are 0.
- R4: An accepted erase gives exactly one `array_clr` pulse. `array_busy` and status bit 0 stay high for exactly ERASE_CYCLES clock cycles. The write-enable latch reads 0 during the erase.
- R5: Opcode 0x05 (status read) drives the status byte {000, protect[2:0], WEL, WIP} MSB first on `so`. Each bit changes after a serial-clock falling edge. `so_oe` is high only during this readout.
- R6: While an erase runs, only status read is honoured. Write enable, a second erase and power-down are ignored, and the erase runs to its full length.
- R7: Opcode 0xB9 (power-down) makes `pd_active` rise exactly PD_ENTER_CYCLES clock cycles after the command is accepted.
- R8: In power-down every command except 0xAB is ignored, including status read, which produces no output enable.
- R9: Opcode 0xAB (release) in power-down makes `pd_active` fall exactly PD_EXIT_CYCLES cycles after acceptance. Opcode 0xAB while active does nothing.
- R10: After reset the controller is active, not busy, `so_oe` is 0, and the status reads 0x00 when the protect inputs are 0.
- R11: Commands and status readout behave the same with serial clock idling low (mode 0) and idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on sck rising edges |
| bp_cfg | input | 3 | Nonvolatile block-protect bits BP2..BP0 |
| so | output | 1 | Serial data out, valid when so_oe is 1 |
| so_oe | output | 1 | Output enable for so; low means high-impedance |
| array_clr | output | 1 | One-cycle strobe that sets the whole array to ones |
| array_busy | output | 1 | High while an erase is timed |
| pd_active | output | 1 | High while in deep power-down, including the exit delay |

## Verification
Command framing is tried with 7, 8 and 9 clocked bits and in both clock polarities. This separates a decoder that counts bits exactly from one that acts on any byte seen. Erase is tried with the write-enable latch clear, with a protect bit set, and with both conditions met. It is also flooded with write enable, erase and power-down traffic mid-run, which shows whether the gating conditions and the busy lockout are separate. Power-down entry and exit are sampled one cycle before and at the programmed delay. Inside power-down, status read, write enable, erase and a short release are sent, and each must leave the state untouched.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_CE   = 8'hC7;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    localparam int OPCODE_BITS = 8;
    localparam int CNT_W       = 4;

    typedef enum logic [1:0] {
        PWR_ON    = 2'd0,
        PWR_ENTER = 2'd1,
        PWR_DOWN  = 2'd2,
        PWR_LEAVE = 2'd3
    } pwr_e;

    typedef struct packed {
        logic       fire;
        logic [7:0] op;
    } cmd_t;

    typedef struct packed {
        logic [2:0] bp;
        logic       wel;
        logic       wip;
    } stat_t;

    function automatic logic [7:0] pack_status(input stat_t s);
        return {3'b000, s.bp, s.wel, s.wip};
    endfunction

    // Saturates one past the opcode length so that overlong frames stay invalid
    function automatic logic [CNT_W-1:0] bit_cnt_next(input logic [CNT_W-1:0] c);
        return (c == CNT_W'(OPCODE_BITS + 1)) ? c : c + CNT_W'(1);
    endfunction

endpackage

// File: rtl/sfc_rx.sv
module sfc_rx
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    output cmd_t       cmd,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       sck_fall
);

    logic             sck_q;
    logic             cs_q;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] cnt;
    logic             sck_rise;
    logic             cs_rise;

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;

    assign byte_val  = {shreg[6:0], si};
    assign byte_done = sck_rise && (cnt == CNT_W'(OPCODE_BITS - 1));

    assign cmd.fire = cs_rise && (cnt == CNT_W'(OPCODE_BITS));
    assign cmd.op   = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[6:0], si};
                cnt   <= bit_cnt_next(cnt);
            end
        end
    end

endmodule

// File: rtl/sfc_tx.sv
module sfc_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       start,
    input  logic       sck_fall,
    input  logic [7:0] stat_byte,
    output logic       so,
    output logic       so_oe
);

    logic       rd_mode;
    logic [2:0] idx;
    logic [7:0] snap;
    logic       so_q;

    assign so_oe = rd_mode & ~cs_n;
    assign so    = so_oe & so_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_mode <= 1'b0;
            idx     <= 3'd7;
            snap    <= '0;
            so_q    <= 1'b0;
        end else if (cs_n) begin
            rd_mode <= 1'b0;
            idx     <= 3'd7;
        end else begin
            if (start) begin
                rd_mode <= 1'b1;
            end
            if (rd_mode && sck_fall) begin
                if (idx == 3'd7) begin
                    snap <= stat_byte;
                    so_q <= stat_byte[7];
                end else begin
                    so_q <= snap[idx];
                end
                idx <= idx - 3'd1;
            end
        end
    end

endmodule

// File: rtl/sfc_countdown.sv
module sfc_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         busy,
    output logic         done
);

    logic [W-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (busy) begin
            cnt <= cnt - W'(1);
        end
    end

endmodule

// File: rtl/spi_flash_cmd_ctrl.sv
module spi_flash_cmd_ctrl
    import sfc_pkg::*;
#(
    parameter int ERASE_CYCLES    = 100000,
    parameter int PD_ENTER_CYCLES = 64,
    parameter int PD_EXIT_CYCLES  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic [2:0] bp_cfg,
    output logic       so,
    output logic       so_oe,
    output logic       array_clr,
    output logic       array_busy,
    output logic       pd_active
);

    localparam int EW   = $clog2(ERASE_CYCLES + 1);
    localparam int PMAX = (PD_ENTER_CYCLES > PD_EXIT_CYCLES) ? PD_ENTER_CYCLES : PD_EXIT_CYCLES;
    localparam int PW   = $clog2(PMAX + 1);

    cmd_t       cmd;
    logic       byte_done;
    logic [7:0] byte_val;
    logic       sck_fall;
    pwr_e       pst;
    logic       wel;
    logic       wip;
    logic       erase_done;
    logic       p_busy;
    logic       p_done;
    stat_t      stat;
    logic       idle_on;
    logic       ce_ok, wren_ok, dp_ok, res_ok, rd_start;
    logic       clr_q;

    sfc_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .cmd      (cmd),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .sck_fall (sck_fall)
    );

    assign idle_on  = (pst == PWR_ON) && !wip;
    assign wren_ok  = cmd.fire && idle_on && (cmd.op == OP_WREN);
    assign dp_ok    = cmd.fire && idle_on && (cmd.op == OP_DP);
    assign ce_ok    = cmd.fire && idle_on && (cmd.op == OP_CE) && wel && (bp_cfg == 3'b000);
    assign res_ok   = cmd.fire && (pst == PWR_DOWN) && (cmd.op == OP_RES);
    assign rd_start = byte_done && (byte_val == OP_RDSR) && (pst == PWR_ON);

    sfc_countdown #(.W(EW)) u_erase_tmr (
        .clk (clk),
        .rst (rst),
        .load(ce_ok),
        .val (EW'(ERASE_CYCLES)),
        .busy(wip),
        .done(erase_done)
    );

    sfc_countdown #(.W(PW)) u_pwr_tmr (
        .clk (clk),
        .rst (rst),
        .load(dp_ok | res_ok),
        .val (dp_ok ? PW'(PD_ENTER_CYCLES) : PW'(PD_EXIT_CYCLES)),
        .busy(p_busy),
        .done(p_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel   <= 1'b0;
            clr_q <= 1'b0;
            pst   <= PWR_ON;
        end else begin
            clr_q <= ce_ok;
            if (ce_ok) begin
                wel <= 1'b0;
            end else if (wren_ok) begin
                wel <= 1'b1;
            end
            case (pst)
                PWR_ON:    if (dp_ok)  pst <= PWR_ENTER;
                PWR_ENTER: if (p_done) pst <= PWR_DOWN;
                PWR_DOWN:  if (res_ok) pst <= PWR_LEAVE;
                PWR_LEAVE: if (p_done) pst <= PWR_ON;
                default:               pst <= PWR_ON;
            endcase
        end
    end

    assign stat.bp  = bp_cfg;
    assign stat.wel = wel;
    assign stat.wip = wip;

    sfc_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .start    (rd_start),
        .sck_fall (sck_fall),
        .stat_byte(pack_status(stat)),
        .so       (so),
        .so_oe    (so_oe)
    );

    assign array_clr  = clr_q;
    assign array_busy = wip;
    assign pd_active  = (pst == PWR_DOWN) || (pst == PWR_LEAVE);

    logic unused_ok;
    assign unused_ok = erase_done ^ p_busy;

endmodule

// File: rtl/sfc_chk.sv
module sfc_chk (
    input logic clk,
    input logic rst,
    input logic array_clr,
    input logic array_busy,
    input logic pd_active,
    input logic so_oe
);

    // R4
    clr_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
        array_clr |-> array_busy);

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(array_busy) |-> array_clr);

    // R6
    single_clr_chk: assert property (@(posedge clk) disable iff (rst)
        array_clr |=> !array_clr);

    // R6
    no_pd_in_erase_chk: assert property (@(posedge clk) disable iff (rst)
        array_busy |-> !pd_active);

    // R8
    no_read_in_pd_chk: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> !so_oe);

endmodule

bind spi_flash_cmd_ctrl sfc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .array_clr (array_clr),
    .array_busy(array_busy),
    .pd_active (pd_active),
    .so_oe     (so_oe)
);

// File: tb/spi_flash_cmd_ctrl_tb.sv
module spi_flash_cmd_ctrl_tb;

    localparam int ERASE = 400;
    localparam int DPC   = 12;
    localparam int RESC  = 9;

    localparam logic [7:0] C_WREN = 8'h06;
    localparam logic [7:0] C_RDSR = 8'h05;
    localparam logic [7:0] C_CE   = 8'hC7;
    localparam logic [7:0] C_DP   = 8'hB9;
    localparam logic [7:0] C_RES  = 8'hAB;

    // {opcode, bit count, mode3, expected status afterwards}
    localparam int NV = 5;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {8'h06, 4'd7, 1'b0, 8'h00},
        {8'h06, 4'd9, 1'b0, 8'h00},
        {8'h06, 4'd8, 1'b1, 8'h02},
        {8'hAB, 4'd8, 1'b0, 8'h02},
        {8'h06, 4'd8, 1'b0, 8'h02}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic [2:0] bp_cfg = 3'b000;
    logic       so, so_oe, array_clr, array_busy, pd_active;

    int n_chk = 0;
    int n_fail = 0;
    int clr_cnt = 0;
    int busy_cnt = 0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_flash_cmd_ctrl #(
        .ERASE_CYCLES   (ERASE),
        .PD_ENTER_CYCLES(DPC),
        .PD_EXIT_CYCLES (RESC)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .bp_cfg    (bp_cfg),
        .so        (so),
        .so_oe     (so_oe),
        .array_clr (array_clr),
        .array_busy(array_busy),
        .pd_active (pd_active)
    );

    always @(negedge clk) begin
        if (array_clr)  clr_cnt++;
        if (array_busy) busy_cnt++;
        if (so_oe)      oe_seen = 1'b1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic rb);
        sck = 1'b0;
        si  = b;
        repeat (2) @(negedge clk);
        rb  = so;
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] op, input int nbits, input bit mode3,
                        input bit rd, output logic [7:0] rv);
        logic rb;
        rv  = '0;
        sck = mode3;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_bit((i < 8) ? op[7-i] : 1'b0, rb);
        end
        if (rd) begin
            for (int j = 0; j < 8; j++) begin
                spi_bit(1'b0, rb);
                rv = {rv[6:0], rb};
            end
        end
        if (!mode3) begin
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        xfer(op, 8, 1'b0, 1'b0, d);
    endtask

    task automatic rd_status(input bit mode3, output logic [7:0] v);
        xfer(C_RDSR, 8, mode3, 1'b1, v);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R10 reset state
        check("R10 so_oe", so_oe, 0);
        check("R10 busy", array_busy, 0);
        check("R10 pd", pd_active, 0);
        rd_status(1'b0, st);
        check("R10 R5 status", st, 8'h00);

        // R3 erase without write enable
        c0 = clr_cnt;
        cmd(C_CE);
        check("R3 no wel clr", clr_cnt - c0, 0);
        check("R3 no wel busy", array_busy, 0);

        // Vector table: R1 R2 R9 R11
        for (int k = 0; k < NV; k++) begin
            xfer(VEC[k][20:13], int'(VEC[k][12:9]), VEC[k][8], 1'b0, st);
            rd_status(1'b0, st);
            check($sformatf("R1 R2 R9 R11 vec%0d", k), st, VEC[k][7:0]);
        end
        rd_status(1'b1, st);
        check("R11 R5 mode3 read", st, 8'h02);

        // R3 protect bits block erase (status bit 3 = BP1)
        bp_cfg = 3'b010;
        c0 = clr_cnt;
        cmd(C_CE);
        check("R3 protect clr", clr_cnt - c0, 0);
        check("R3 protect busy", array_busy, 0);
        rd_status(1'b0, st);
        check("R3 R5 protect status", st, 8'h0A);
        bp_cfg = 3'b000;

        // R4 erase timing
        c0 = clr_cnt;
        busy_cnt = 0;
        cmd(C_CE);
        for (int t = 0; t < ERASE + 20 && array_busy; t++) @(negedge clk);
        check("R4 clr pulses", clr_cnt - c0, 1);
        check("R4 busy cycles", busy_cnt, ERASE);

        // R6 traffic during erase
        cmd(C_WREN);
        c0 = clr_cnt;
        busy_cnt = 0;
        cmd(C_CE);
        rd_status(1'b0, st);
        check("R4 R6 status in erase", st, 8'h01);
        cmd(C_WREN);
        cmd(C_CE);
        cmd(C_DP);
        check("R6 still busy", array_busy, 1);
        for (int t = 0; t < ERASE + 20 && array_busy; t++) @(negedge clk);
        check("R6 one clr", clr_cnt - c0, 1);
        check("R6 full erase", busy_cnt, ERASE);
        repeat (DPC + 4) @(negedge clk);
        check("R6 dp rejected", pd_active, 0);
        rd_status(1'b0, st);
        check("R6 status after", st, 8'h00);

        // R7 power-down entry timing
        cmd(C_DP);
        check("R7 not yet", pd_active, 0);
        repeat (DPC - 3) @(negedge clk);
        check("R7 one before", pd_active, 0);
        @(negedge clk);
        check("R7 entered", pd_active, 1);

        // R8 lockout
        oe_seen = 1'b0;
        rd_status(1'b0, st);
        check("R8 no readout", oe_seen, 0);
        cmd(C_WREN);
        c0 = clr_cnt;
        cmd(C_CE);
        check("R8 no erase", clr_cnt - c0, 0);
        xfer(C_RES, 7, 1'b0, 1'b0, st);
        repeat (RESC + 4) @(negedge clk);
        check("R1 R8 short release", pd_active, 1);

        // R9 release timing
        cmd(C_RES);
        check("R9 still down", pd_active, 1);
        repeat (RESC - 3) @(negedge clk);
        check("R9 one before", pd_active, 1);
        @(negedge clk);
        check("R9 released", pd_active, 0);
        rd_status(1'b0, st);
        check("R8 R9 wren ignored", st, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule